// File: doc/BRIEF.md
# Ramped Step Clock Synthesizer

This block produces a square-wave step clock for a stepper motor driver. A 16-bit phase accumulator advances by a phase increment on every sample tick. The accumulator wraps on overflow, and each wrap is one output period. The step clock is the accumulator's top bit. The output frequency is therefore the sample rate times the increment, divided by 65536. With a sample rate of 6553.6 Hz, one increment unit equals 0.1 Hz.

The increment is never loaded from the speed command directly. A second, slower tick moves it one unit toward the command, so the output frequency sweeps in a straight line instead of jumping. With a 10 ms ramp period the slope is 10 Hz per second. Commands above a configurable ceiling (2000 by default, about 200 Hz) are clamped to that ceiling. This keeps the output in the range where short-term period jitter stays small.

Both ticks come from free-running modulo counters of the system clock. The sample period is fixed and does not depend on the output frequency.

Top module: `ramp_step_clk_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears the accumulator, the increment and both tick counters. After that edge, `incr_out` reads 0 and `step_clk` is low.
- R2: A sample tick occurs on every SAMPLE_DIV-th clock edge after reset is released. On that edge the accumulator takes (accumulator + increment) mod 65536. On all other edges it holds its value.
- R3: `step_clk` equals bit 15 of the accumulator, so it can change only on a sample-tick edge.
- R4: A ramp tick occurs on every RAMP_DIV-th clock edge after reset is released. On that edge the increment rises by 1 if it is below the target, falls by 1 if it is above, and otherwise holds. On all other edges it holds.
- R5: The target is `speed_cmd` clamped to MAX_SPEED. `incr_out` never exceeds MAX_SPEED, and a command above MAX_SPEED drives it to exactly MAX_SPEED.
- R6: When a sample tick and a ramp tick fall on the same edge, the accumulator adds the increment value from before that edge's ramp adjustment.
- R7: The slew direction is taken from the command value present at each ramp tick. If the command changes during a ramp, the increment reverses and settles on the new target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| speed_cmd | input | INC_W | Commanded increment (0.1 Hz units at the nominal sample rate) |
| step_clk | output | 1 | Square-wave step clock, the accumulator's top bit |
| incr_out | output | INC_W | Current phase increment after slewing |

## Verification
The first pattern is a rise from rest to a small command. It separates a correct one-unit-per-tick slope from jumps and from steps made at the wrong rate. The second pattern lowers the command, and a third reverses it part-way through a rise; these test both slew directions and that each ramp tick uses the command present at that tick. The fourth pattern is an all-ones command. It shows whether the clamp holds the increment at the ceiling, and it runs the accumulator at its fastest, so wraps happen often. With sample and ramp periods that share edges, a reference model followed every cycle can tell a design that uses the pre-adjust increment from one that uses the adjusted increment. A final reset in the middle of a run checks that all state clears.

// File: rtl/rsc_pkg.sv
// Shared types for the ramped step clock synthesizer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package rsc_pkg;

    // Direction decided for the increment at a ramp tick.
    typedef enum logic [1:0] {
        SLEW_HOLD = 2'd0,
        SLEW_UP   = 2'd1,
        SLEW_DOWN = 2'd2
    } slew_dir_t;

endpackage

// File: rtl/rsc_tick_gen.sv
// Free-running modulo counter that emits a one-cycle tick on every DIV-th
// clock edge after reset is released.
// Assumes DIV >= 1; DIV == 1 gives a tick in every cycle.
module rsc_tick_gen #(
    parameter int unsigned DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    // Decode the terminal count; the consumers act on this edge.
    always_comb tick = (cnt_q == LAST);

    // Advance the counter and wrap it at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/rsc_slew.sv
// Holds the phase increment and moves it one unit per ramp tick toward the
// speed command, after clamping the command to MAX_SPEED.
// Assumes MAX_SPEED fits in INC_W bits.
module rsc_slew
    import rsc_pkg::*;
#(
    parameter int unsigned INC_W     = 16,
    parameter int unsigned MAX_SPEED = 2000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ramp_tick,
    input  logic [INC_W-1:0] speed_cmd,
    output logic [INC_W-1:0] incr_q
);
    localparam logic [INC_W-1:0] CEIL = INC_W'(MAX_SPEED);

    logic [INC_W-1:0] target;
    slew_dir_t        dir;

    // Limit the command to the allowed ceiling.
    always_comb target = (speed_cmd > CEIL) ? CEIL : speed_cmd;

    // Choose the slew direction from the clamped target.
    always_comb begin
        if (incr_q < target)      dir = SLEW_UP;
        else if (incr_q > target) dir = SLEW_DOWN;
        else                      dir = SLEW_HOLD;
    end

    // Step the increment by one unit on each ramp tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            incr_q <= '0;
        end else if (ramp_tick) begin
            unique case (dir)
                SLEW_UP:   incr_q <= incr_q + 1'b1;
                SLEW_DOWN: incr_q <= incr_q - 1'b1;
                default:   incr_q <= incr_q;
            endcase
        end
    end
endmodule

// File: rtl/rsc_phase_acc.sv
// Wrapping phase accumulator. It adds the increment on each sample tick and
// outputs its top bit as a square wave.
// Assumes INC_W <= ACC_W. The increment input is the value registered
// before the current edge.
module rsc_phase_acc #(
    parameter int unsigned ACC_W = 16,
    parameter int unsigned INC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_tick,
    input  logic [INC_W-1:0] incr,
    output logic             msb
);
    logic [ACC_W-1:0] acc_q;

    // Accumulate phase with natural wrap on overflow.
    always_ff @(posedge clk) begin
        if (!rst_n)           acc_q <= '0;
        else if (sample_tick) acc_q <= acc_q + ACC_W'(incr);
    end

    // Bring out the top bit as the square-wave output.
    always_comb msb = acc_q[ACC_W-1];
endmodule

// File: rtl/ramp_step_clk_gen.sv
// Top of the ramped step clock synthesizer: two tick generators, the
// increment slew and the phase accumulator.
// Assumes a synchronous active-low reset and a speed_cmd that is stable
// in the clock domain.
module ramp_step_clk_gen #(
    parameter int unsigned ACC_W      = 16,
    parameter int unsigned INC_W      = 16,
    parameter int unsigned MAX_SPEED  = 2000,
    parameter int unsigned SAMPLE_DIV = 15259,
    parameter int unsigned RAMP_DIV   = 1000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INC_W-1:0] speed_cmd,
    output logic             step_clk,
    output logic [INC_W-1:0] incr_out
);
    logic sample_tick;
    logic ramp_tick;
    logic [INC_W-1:0] incr;

    rsc_tick_gen #(.DIV(SAMPLE_DIV)) u_sample_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (sample_tick)
    );

    rsc_tick_gen #(.DIV(RAMP_DIV)) u_ramp_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (ramp_tick)
    );

    rsc_slew #(.INC_W(INC_W), .MAX_SPEED(MAX_SPEED)) u_slew (
        .clk      (clk),
        .rst_n    (rst_n),
        .ramp_tick(ramp_tick),
        .speed_cmd(speed_cmd),
        .incr_q   (incr)
    );

    rsc_phase_acc #(.ACC_W(ACC_W), .INC_W(INC_W)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_tick(sample_tick),
        .incr       (incr),
        .msb        (step_clk)
    );

    // Expose the slewed increment.
    always_comb incr_out = incr;
endmodule

// File: rtl/rsc_checker.sv
// Temporal checks for ramp_step_clk_gen, bound to every instance of it.
// Assumes the internal tick nets named sample_tick and ramp_tick.
module rsc_checker #(
    parameter int unsigned INC_W      = 16,
    parameter int unsigned MAX_SPEED  = 2000,
    parameter int unsigned SAMPLE_DIV = 15259,
    parameter int unsigned RAMP_DIV   = 1000000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sample_tick,
    input logic             ramp_tick,
    input logic [INC_W-1:0] speed_cmd,
    input logic [INC_W-1:0] incr_out,
    input logic             step_clk
);
    localparam logic [INC_W-1:0] CEIL = INC_W'(MAX_SPEED);
    logic [INC_W-1:0] goal;

    // Clamped command as seen by the checker.
    always_comb goal = (speed_cmd > CEIL) ? CEIL : speed_cmd;

    // R1: reset clears the visible state.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (incr_out == '0 && !step_clk));

    // R3: the step output moves only on a sample-tick edge.
    p_step_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_tick |=> $stable(step_clk));

    // R4: the increment holds between ramp ticks.
    p_incr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ramp_tick |=> $stable(incr_out));

    // R4: the increment never moves by more than one unit.
    p_incr_unit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (incr_out == $past(incr_out) ||
                  incr_out == $past(incr_out) + 1'b1 ||
                  incr_out == $past(incr_out) - 1'b1));

    // R4: below the target, a ramp tick raises the increment.
    p_incr_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_tick && incr_out < goal) |=> incr_out == $past(incr_out) + 1'b1);

    // R7: above the current command, a ramp tick lowers the increment.
    p_incr_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_tick && incr_out > goal) |=> incr_out == $past(incr_out) - 1'b1);

    // R5: the increment never exceeds the ceiling.
    p_incr_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        incr_out <= CEIL);

    // R2: sample ticks are single-cycle pulses when the period exceeds one.
    generate
        if (SAMPLE_DIV > 1) begin : g_sample_pulse
            p_sample_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
                sample_tick |=> !sample_tick);
        end
        if (RAMP_DIV > 1) begin : g_ramp_pulse
            p_ramp_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
                ramp_tick |=> !ramp_tick);
        end
    endgenerate
endmodule

bind ramp_step_clk_gen rsc_checker #(
    .INC_W     (INC_W),
    .MAX_SPEED (MAX_SPEED),
    .SAMPLE_DIV(SAMPLE_DIV),
    .RAMP_DIV  (RAMP_DIV)
) u_rsc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_tick(sample_tick),
    .ramp_tick  (ramp_tick),
    .speed_cmd  (speed_cmd),
    .incr_out   (incr_out),
    .step_clk   (step_clk)
);

// File: tb/ramp_step_clk_gen_bench.sv
// Directed bench for ramp_step_clk_gen. A cycle model built from the
// requirements is compared with the outputs at every falling edge.
module ramp_step_clk_gen_bench;
    localparam int unsigned SD  = 3;
    localparam int unsigned RD  = 8;
    localparam int unsigned MAXS = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] speed_cmd = '0;
    logic        step_clk;
    logic [15:0] incr_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Reference model state.
    int          m_sc = 0;
    int          m_rc = 0;
    logic [15:0] m_acc = '0;
    logic [15:0] m_incr = '0;
    logic [15:0] m_old;
    logic [15:0] m_tgt;
    bit          m_s, m_r;
    bit          m_both = 0;

    always #5 clk = ~clk;

    ramp_step_clk_gen #(
        .ACC_W(16), .INC_W(16), .MAX_SPEED(MAXS),
        .SAMPLE_DIV(SD), .RAMP_DIV(RD)
    ) u_ramp_step_clk_gen (
        .clk(clk), .rst_n(rst_n), .speed_cmd(speed_cmd),
        .step_clk(step_clk), .incr_out(incr_out)
    );

    // Model: tick periods, wrapping add with pre-adjust increment, clamped slew.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_sc = 0; m_rc = 0; m_acc = '0; m_incr = '0; m_both = 0;
        end else begin
            m_old = m_incr;
            m_s = (m_sc == SD - 1);
            m_r = (m_rc == RD - 1);
            m_sc = m_s ? 0 : m_sc + 1;
            m_rc = m_r ? 0 : m_rc + 1;
            m_tgt = (speed_cmd > 16'(MAXS)) ? 16'(MAXS) : speed_cmd;
            if (m_s) m_acc = m_acc + m_old;
            if (m_r) begin
                if (m_incr < m_tgt)      m_incr = m_incr + 16'd1;
                else if (m_incr > m_tgt) m_incr = m_incr - 16'd1;
            end
            m_both = m_s && m_r;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare both outputs with the model for n cycles.
    task automatic run_cycles(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(tag, incr_out, m_incr);
            chk(m_both ? "R6" : "R3", {15'd0, step_clk}, {15'd0, m_acc[15]});
        end
    endtask

    task automatic t_reset;
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", incr_out, 16'd0);
        chk("R1", {15'd0, step_clk}, 16'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_ramp_up;
        speed_cmd = 16'd40;
        run_cycles(40 * RD + 30, "R4");
        chk("R4", incr_out, 16'd40);
    endtask

    task automatic t_ramp_down;
        speed_cmd = 16'd10;
        run_cycles(30 * RD + 30, "R4");
        chk("R4", incr_out, 16'd10);
    endtask

    task automatic t_reverse;
        speed_cmd = 16'd60;
        run_cycles(12 * RD, "R7");
        speed_cmd = 16'd15;
        run_cycles(12 * RD + 20, "R7");
        chk("R7", incr_out, 16'd15);
    endtask

    task automatic t_clamp;
        speed_cmd = 16'hFFFF;
        run_cycles((MAXS - 15) * RD + 80, "R5");
        chk("R5", incr_out, 16'(MAXS));
        run_cycles(700, "R2");
        chk("R5", incr_out, 16'(MAXS));
    endtask

    task automatic t_midreset;
        t_reset();
        speed_cmd = 16'd5;
        run_cycles(8 * RD, "R2");
        chk("R4", incr_out, 16'd5);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_ramp_up();
        t_ramp_down();
        t_reverse();
        t_clamp();
        t_midreset();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule